// File: doc/BRIEF.md
# UART Receiver with Idle-Line Detection

This block is the receive half of an asynchronous serial port. It watches the serial input using a sample tick that runs at sixteen times the bit rate. It assembles each character least significant bit first, with 8 or 9 data bits, and hands the finished word to a data register that a processor reads. Each received word reports four conditions as separate status flags: receive-full, overrun, noise and framing error.

The block also detects an idle line, which means the line has stayed high for a full character time. Software uses this to find where one message ends and the next begins. The idle flag is armed only by a character that arrived with a valid stop bit, and each arming allows one idle report. A sleep bit lets the receiver ignore traffic that is not meant for it until the line next goes idle. The interrupt output combines the receive condition and the idle condition, and each has its own enable. The sample tick comes from outside the block.

Top module: `uart_rx_idle`

## Requirements
- R1: With `nine_bit_i` low, a frame of one low start bit, 8 data bits (first bit on the line is bit 0) and a high stop bit loads those bits into `data_o[7:0]`, and `data_o[8]` reads 0.
- R2: With `nine_bit_i` high, the frame carries 9 data bits (first on the line is bit 0), and all 9 appear on `data_o[8:0]`.
- R3: `full_o` rises exactly two clock cycles after a cycle where `tick16_i` was high. `irq_o` is high while `full_o` is set and `full_ie_i` is high, and low when `full_ie_i` is low and no idle interrupt is pending.
- R4: Each bit is sampled on sample ticks 7, 8 and 9 counted from the bit's first tick, and the majority value is kept. If any one of the three samples disagrees, the word is delivered with the correct data and `noise_o` set.
- R5: If the majority value of the stop bit is low, the word is still delivered and `frame_err_o` is set.
- R6: A word that completes while `full_o` is still set is dropped. `overrun_o` is set, and `data_o` keeps the earlier word.
- R7: If the start bit's majority value is high (a glitch shorter than 7 ticks), reception stops and no word is delivered.
- R8: After a character with a valid stop bit, the line must stay high for 16×(data bits+2) sample ticks, counted from the end of the frame, before `idle_o` is set. This happens once per such character, and never before the first one.
- R9: `irq_o` is high while `idle_o` and `idle_ie_i` are both high.
- R10: A one-cycle pulse on `sleep_set_i` sets `sleep_o`. While asleep, words complete without setting any flag and the idle flag stays low. One idle time of high line clears `sleep_o`.
- R11: Flags clear only when a `status_rd_i` pulse, made while a flag was set, is later followed by a `data_rd_i` pulse. A `data_rd_i` pulse alone clears nothing.
- R12: While `rx_en_i` is low, `data_o` reads 0 and no word is received. The stored word reappears when the receiver is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial input line, idle high |
| tick16_i | input | 1 | One-cycle sample strobe at 16× the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| full_ie_i | input | 1 | Interrupt enable for receive-full and overrun |
| idle_ie_i | input | 1 | Interrupt enable for idle line |
| sleep_set_i | input | 1 | Pulse that puts the receiver to sleep |
| status_rd_i | input | 1 | Status-read strobe, first step of flag clear |
| data_rd_i | input | 1 | Data-read strobe, second step of flag clear |
| data_o | output | 9 | Last received word (0 while disabled) |
| full_o | output | 1 | Receive-full flag |
| overrun_o | output | 1 | Overrun flag |
| noise_o | output | 1 | Noise flag |
| frame_err_o | output | 1 | Framing error flag |
| idle_o | output | 1 | Idle-line flag |
| sleep_o | output | 1 | Sleep (wake-up pending) state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench puts a one-tick glitch on the middle sample of a data bit. A receiver that uses a single sample would corrupt the data, and one that ignores disagreement would leave the noise flag clear. It sends a low stop bit, where a receiver that drops the word or misses the check would fail the compare, and a short low pulse, where a receiver without a start-bit recheck would deliver a false word. For idle, it checks just before and just after the threshold and again after the flag is cleared. A wrong count, or an idle report that is not tied to one valid character, shows up as an early, late or repeated flag. The remaining cases are overrun while full, a data read with no status read before it, reception while asleep, and reception while disabled. A design that overwrote, cleared or accepted a word in any of these cases would show a wrong `data_o` or a wrong flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int unsigned RX_WORD_W = 9;

  typedef enum logic {FR_IDLE, FR_BUSY} fr_state_e;

  typedef struct packed {
    logic [RX_WORD_W-1:0] data;
    logic                 noise;
    logic                 ferr;
  } rx_word_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     tick_i,
  input  logic     line_i,
  input  logic     nine_i,
  output logic     busy_o,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int unsigned PH_W  = $clog2(OSR);
  localparam int unsigned IDX_W = $clog2(RX_WORD_W + 2);
  localparam logic [PH_W-1:0]  PH_S0  = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0]  PH_S1  = PH_W'(OSR/2);
  localparam logic [PH_W-1:0]  PH_S2  = PH_W'(OSR/2 + 1);
  localparam logic [PH_W-1:0]  PH_END = PH_W'(OSR - 1);
  localparam logic [IDX_W-1:0] STOP_LONG  = IDX_W'(RX_WORD_W + 1);
  localparam logic [IDX_W-1:0] STOP_SHORT = IDX_W'(RX_WORD_W);

  fr_state_e            state_q;
  logic [PH_W-1:0]      phase_q;
  logic [IDX_W-1:0]     idx_q;
  logic [1:0]           smp_q;
  logic                 noise_q;
  logic [RX_WORD_W-1:0] data_q;

  logic             maj, disagree;
  logic [IDX_W-1:0] stop_idx, dpos;

  always_comb begin
    stop_idx = nine_i ? STOP_LONG : STOP_SHORT;
    maj      = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) | (smp_q[1] & line_i);
    disagree = !((smp_q[0] == smp_q[1]) && (smp_q[1] == line_i));
    dpos     = idx_q - IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FR_IDLE;
      phase_q <= '0;
      idx_q   <= '0;
      smp_q   <= '0;
      noise_q <= 1'b0;
      data_q  <= '0;
      done_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= FR_IDLE;
      end else if (tick_i) begin
        unique case (state_q)
          FR_IDLE: begin
            if (!line_i) begin
              // this tick is phase 0 of the start bit
              state_q <= FR_BUSY;
              phase_q <= PH_W'(1);
              idx_q   <= '0;
              noise_q <= 1'b0;
              data_q  <= '0;
            end
          end
          FR_BUSY: begin
            phase_q <= (phase_q == PH_END) ? '0 : phase_q + 1'b1;
            if (phase_q == PH_END) idx_q <= idx_q + 1'b1;
            if (phase_q == PH_S0) smp_q[0] <= line_i;
            if (phase_q == PH_S1) smp_q[1] <= line_i;
            if (phase_q == PH_S2) begin
              noise_q <= noise_q | disagree;
              if (idx_q == '0) begin
                if (maj) state_q <= FR_IDLE;  // false start
              end else if (idx_q == stop_idx) begin
                // finish at mid stop bit so the next start edge is caught early
                state_q     <= FR_IDLE;
                done_o      <= 1'b1;
                word_o.data <= data_q;
                word_o.noise <= noise_q | disagree;
                word_o.ferr <= !maj;
              end else begin
                data_q[dpos] <= maj;
              end
            end
          end
          default: state_q <= FR_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q == FR_BUSY);
endmodule

// File: rtl/uart_rx_idle_det.sv
module uart_rx_idle_det
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic busy_i,
  input  logic restart_i,
  input  logic nine_i,
  output logic idle_o
);
  localparam int unsigned CNT_W = $clog2(OSR * (RX_WORD_W + 2) + 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(OSR * (RX_WORD_W + 2));
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(OSR * (RX_WORD_W + 1));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = nine_i ? LIM_LONG : LIM_SHORT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_o <= 1'b0;
    end else begin
      idle_o <= 1'b0;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (busy_i || !line_i) begin
          cnt_q <= '0;
        end else if (cnt_q < limit) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == limit - 1'b1) idle_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  rx_word_t             word_i,
  input  logic                 sleep_set_i,
  input  logic                 idle_det_i,
  input  logic                 status_rd_i,
  input  logic                 data_rd_i,
  output logic [RX_WORD_W-1:0] data_o,
  output logic                 full_o,
  output logic                 overrun_o,
  output logic                 noise_o,
  output logic                 frame_err_o,
  output logic                 idle_o,
  output logic                 sleep_o
);
  logic seen_q, arm_q;
  logic any_flag, clr, take, accept;

  always_comb begin
    any_flag = full_o | overrun_o | noise_o | frame_err_o | idle_o;
    clr      = data_rd_i & seen_q;
    take     = done_i & ~sleep_o;
    accept   = take & (~full_o | clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      arm_q       <= 1'b0;
      data_o      <= '0;
      full_o      <= 1'b0;
      overrun_o   <= 1'b0;
      noise_o     <= 1'b0;
      frame_err_o <= 1'b0;
      idle_o      <= 1'b0;
      sleep_o     <= 1'b0;
    end else begin
      if (clr)                          seen_q <= 1'b0;
      else if (status_rd_i && any_flag) seen_q <= 1'b1;

      if (clr) begin
        full_o      <= 1'b0;
        overrun_o   <= 1'b0;
        noise_o     <= 1'b0;
        frame_err_o <= 1'b0;
        idle_o      <= 1'b0;
      end
      if (accept) begin
        data_o      <= word_i.data;
        full_o      <= 1'b1;
        noise_o     <= word_i.noise;
        frame_err_o <= word_i.ferr;
      end else if (take) begin
        overrun_o <= 1'b1;
      end

      if (idle_det_i && arm_q && !sleep_o) begin
        idle_o <= 1'b1;
        arm_q  <= 1'b0;
      end
      if (take && !word_i.ferr) arm_q <= 1'b1;

      if (sleep_set_i)     sleep_o <= 1'b1;
      else if (idle_det_i) sleep_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  input  logic                 tick16_i,
  input  logic                 rx_en_i,
  input  logic                 nine_bit_i,
  input  logic                 full_ie_i,
  input  logic                 idle_ie_i,
  input  logic                 sleep_set_i,
  input  logic                 status_rd_i,
  input  logic                 data_rd_i,
  output logic [RX_WORD_W-1:0] data_o,
  output logic                 full_o,
  output logic                 overrun_o,
  output logic                 noise_o,
  output logic                 frame_err_o,
  output logic                 idle_o,
  output logic                 sleep_o,
  output logic                 irq_o
);
  logic                 line_s, busy, done, idle_det;
  rx_word_t             word;
  logic [RX_WORD_W-1:0] data_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(line_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .tick_i(tick16_i),
    .line_i(line_s), .nine_i(nine_bit_i), .busy_o(busy), .done_o(done),
    .word_o(word)
  );

  uart_rx_idle_det #(.OSR(OSR)) u_idle (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick16_i), .line_i(line_s),
    .busy_i(busy), .restart_i(sleep_set_i), .nine_i(nine_bit_i),
    .idle_o(idle_det)
  );

  uart_rx_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .word_i(word),
    .sleep_set_i(sleep_set_i), .idle_det_i(idle_det),
    .status_rd_i(status_rd_i), .data_rd_i(data_rd_i), .data_o(data_q),
    .full_o(full_o), .overrun_o(overrun_o), .noise_o(noise_o),
    .frame_err_o(frame_err_o), .idle_o(idle_o), .sleep_o(sleep_o)
  );

  assign data_o = rx_en_i ? data_q : '0;
  assign irq_o  = (full_ie_i & (full_o | overrun_o)) | (idle_ie_i & idle_o);
endmodule

// File: rtl/uart_rx_idle_chk.sv
module uart_rx_idle_chk
  import uart_rx_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tick16_i,
  input logic                 rx_en_i,
  input logic                 data_rd_i,
  input logic [RX_WORD_W-1:0] data_o,
  input logic                 full_o,
  input logic                 overrun_o,
  input logic                 idle_o,
  input logic                 sleep_o
);
  logic got_char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     got_char_q <= 1'b0;
    else if (full_o) got_char_q <= 1'b1;
  end

  // R3
  a_r3_full_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(tick16_i, 2));

  // R6
  a_r6_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(overrun_o) && $stable(rx_en_i)) |-> $stable(data_o));

  // R8
  a_r8_idle_after_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> got_char_q);

  // R10
  a_r10_sleep_blocks_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> !$past(sleep_o));

  // R11
  a_r11_full_clears_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(data_rd_i));
endmodule

bind uart_rx_idle uart_rx_idle_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .rx_en_i(rx_en_i),
  .data_rd_i(data_rd_i), .data_o(data_o), .full_o(full_o),
  .overrun_o(overrun_o), .idle_o(idle_o), .sleep_o(sleep_o)
);

// File: tb/uart_rx_idle_tb_top.sv
`timescale 1ns/1ps
module uart_rx_idle_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, rx_en = 1'b1, nine = 1'b0, full_ie = 1'b1, idle_ie = 1'b0;
  logic sleep_set = 1'b0, status_rd = 1'b0, data_rd = 1'b0;
  logic [8:0] data;
  logic full, ovr, nf, fe, idle, sleep, irq;
  logic [1:0] tdiv = 2'd0;
  logic tick16;
  logic auto_rd = 1'b0;
  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  typedef struct {
    logic [8:0] d;
    logic       nf;
    logic       fe;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  uart_rx_idle dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick16_i(tick16), .rx_en_i(rx_en),
    .nine_bit_i(nine), .full_ie_i(full_ie), .idle_ie_i(idle_ie),
    .sleep_set_i(sleep_set), .status_rd_i(status_rd), .data_rd_i(data_rd),
    .data_o(data), .full_o(full), .overrun_o(ovr), .noise_o(nf),
    .frame_err_o(fe), .idle_o(idle), .sleep_o(sleep), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick16) @(negedge clk);
  endtask

  task automatic hold_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  // driver: pushes expectation, then shifts the frame onto the line
  task automatic send_word(input logic [8:0] v, input int nb, input int glitch,
                           input logic stop_v, input logic push, input string tag);
    exp_t e;
    if (push) begin
      e.d   = (nb == 9) ? v : {1'b0, v[7:0]};
      e.nf  = (glitch >= 0);
      e.fe  = !stop_v;
      e.irq = full_ie;
      e.tag = tag;
      sb_q.push_back(e);
    end
    for (int k = 0; k < nb + 2; k++) begin
      logic b;
      b = (k == 0) ? 1'b0 : (k <= nb) ? v[k-1] : stop_v;
      for (int t = 0; t < 16; t++) begin
        wait_tick();
        rx = (k == glitch && t == 8) ? ~b : b;
      end
    end
  endtask

  // monitor: compares each delivered word, then clears via status+data read
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rd && full) begin
        if (sb_q.size() == 0) begin
          chk("R10 unexpected word delivered", 32'(data), 32'h1ff);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({e.tag, " data"}, 32'(data), 32'(e.d));
          chk("R4 noise flag", 32'(nf), 32'(e.nf));
          chk("R5 framing flag", 32'(fe), 32'(e.fe));
          chk("R3 irq on full", 32'(irq), 32'(e.irq));
        end
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0; data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        chk("R11 full cleared by read pair", 32'(full), 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 full reset", 32'(full), 0);
    chk("R6 overrun reset", 32'(ovr), 0);
    chk("R4 noise reset", 32'(nf), 0);
    chk("R5 framing reset", 32'(fe), 0);
    chk("R8 idle reset", 32'(idle), 0);
    chk("R10 sleep reset", 32'(sleep), 0);
    chk("R9 irq reset", 32'(irq), 0);
    chk("R1 data reset", 32'(data), 0);

    hold_ticks(200);
    chk("R8 no idle before any char", 32'(idle), 0);

    auto_rd = 1'b1;
    send_word(9'h0A5, 8, -1, 1'b1, 1'b1, "R1 8-bit A5"); hold_ticks(4);
    full_ie = 1'b0;
    send_word(9'h03C, 8, -1, 1'b1, 1'b1, "R1 8-bit 3C"); hold_ticks(4);
    full_ie = 1'b1;
    send_word(9'h001, 8, -1, 1'b1, 1'b1, "R1 8-bit 01"); hold_ticks(4);
    send_word(9'h080, 8, -1, 1'b1, 1'b1, "R1 8-bit 80"); hold_ticks(4);

    idle_ie = 1'b1;
    hold_ticks(140);
    chk("R8 idle not before threshold", 32'(idle), 0);
    hold_ticks(30);
    chk("R8 idle after frame of ones", 32'(idle), 1);
    chk("R9 irq on idle", 32'(irq), 1);
    pulse(status_rd); pulse(data_rd);
    @(negedge clk);
    chk("R11 idle cleared", 32'(idle), 0);
    chk("R9 irq drops with idle", 32'(irq), 0);
    hold_ticks(200);
    chk("R8 idle only once per char", 32'(idle), 0);

    pulse(sleep_set);
    @(negedge clk);
    chk("R10 sleep set", 32'(sleep), 1);
    send_word(9'h055, 8, -1, 1'b1, 1'b0, "R10 asleep"); hold_ticks(4);
    chk("R10 no full while asleep", 32'(full), 0);
    chk("R10 still asleep", 32'(sleep), 1);
    hold_ticks(200);
    chk("R10 idle line wakes", 32'(sleep), 0);
    chk("R10 idle flag suppressed", 32'(idle), 0);
    send_word(9'h066, 8, -1, 1'b1, 1'b1, "R10 after wake"); hold_ticks(4);

    send_word(9'h05A, 8, 3, 1'b1, 1'b1, "R4 glitched"); hold_ticks(4);
    send_word(9'h0C3, 8, -1, 1'b0, 1'b1, "R5 bad stop");
    rx = 1'b1; hold_ticks(40);

    rx = 1'b0; hold_ticks(3); rx = 1'b1; hold_ticks(40);
    chk("R7 false start gives no word", 32'(full), 0);
    chk("R7 scoreboard drained", 32'(sb_q.size()), 0);
    send_word(9'h07E, 8, -1, 1'b1, 1'b1, "R7 recovery"); hold_ticks(4);

    nine = 1'b1;
    send_word(9'h1A5, 9, -1, 1'b1, 1'b1, "R2 9-bit 1A5"); hold_ticks(4);
    send_word(9'h0FF, 9, -1, 1'b1, 1'b1, "R2 9-bit 0FF"); hold_ticks(4);
    nine = 1'b0;

    auto_rd = 1'b0;
    send_word(9'h011, 8, -1, 1'b1, 1'b0, "R6 first"); hold_ticks(4);
    send_word(9'h022, 8, -1, 1'b1, 1'b0, "R6 second"); hold_ticks(4);
    chk("R6 full held", 32'(full), 1);
    chk("R6 overrun set", 32'(ovr), 1);
    chk("R6 first word kept", 32'(data), 32'h011);
    pulse(data_rd);
    @(negedge clk);
    chk("R11 data read alone keeps full", 32'(full), 1);
    pulse(status_rd); pulse(data_rd);
    @(negedge clk);
    chk("R11 full cleared", 32'(full), 0);
    chk("R11 overrun cleared", 32'(ovr), 0);
    auto_rd = 1'b1;

    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R12 data reads zero when disabled", 32'(data), 0);
    send_word(9'h099, 8, -1, 1'b1, 1'b0, "R12 disabled"); hold_ticks(4);
    chk("R12 no word while disabled", 32'(full), 0);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    chk("R12 stored word returns", 32'(data), 32'h011);

    hold_ticks(10);
    finish_run();
  end
endmodule